// File: doc/BRIEF.md
# Program-Array Checksum Accumulator

This block computes a 16-bit checksum over a stream of program words as a device programmer reads them back. A start strobe opens a run. The block then takes one 14-bit word on each cycle in which the valid strobe is high, until it has taken a fixed number of words (1024 by default). On the cycle after the last word it adds one term derived from the configuration word and raises a done flag. The flag and the result then hold until the next start.

The checksum has two forms, chosen by a protection flag captured at start. With the flag low, every word adds its full value. The configuration term is the low five bits of the configuration word plus a fixed bias of 0x3FE0. With the flag high, every word first folds to seven bits: each bit is the XNOR of a bit in the upper half of the word and the bit at the same position in the lower half. The configuration term is then its low five bits ORed with 0x60. In both forms the result wraps modulo 2^16.

Top module: `cksum_acc`

## Requirements
- R1: After reset, `checksum_o` is 0 and `done_o` is 0.
- R2: On the edge where `start_i` is high, the running sum is cleared, `done_o` falls, and `cfg_i` and `protect_i` are captured. Those captured values are used for the whole run, whatever the inputs do afterwards.
- R3: With the captured protection flag at 0, each accepted word adds its full 14-bit value to the sum.
- R4: With the captured protection flag at 1, each accepted word adds a 7-bit value. Bit k of that value is the XNOR of word bit k+7 and word bit k, so 0x3FFF adds 0x7F and 0x123 adds 0x5E.
- R5: The configuration term is (cfg & 0x1F) + 0x3FE0 when unprotected and (cfg & 0x1F) | 0x60 when protected. Bits 13:5 of the configuration word have no effect.
- R6: The result is the low 16 bits of the total. An all-ones array with an all-ones configuration gives 0x3BFF unprotected and 0xFC7F protected.
- R7: Exactly NUM_WORDS words are accepted. `done_o` is still 0 after the edge that takes the last word and is 1 after the next edge, which adds the configuration term. Valid strobes may have gaps.
- R8: Valid strobes after done, or before any start after reset, leave `checksum_o` unchanged.
- R9: Once high, `done_o` and `checksum_o` hold until the next start.
- R10: A start restarts a run in progress. A word presented in the same cycle as start is not counted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Clears the sum and captures configuration and protection |
| valid_i | input | 1 | A word is present on word_i |
| word_i | input | 14 | Program word |
| cfg_i | input | 14 | Configuration word |
| protect_i | input | 1 | Selects the folded (protected) checksum form |
| checksum_o | output | 16 | Registered checksum |
| done_o | output | 1 | Result complete |

## Verification
On every cycle, the embedded properties check that a start clears the sum and drops done. They also check that done rises only out of the final-term phase with the full word count, and that done and the sum stay frozen afterwards. Further properties check that word acceptance and the configuration add never coincide, and that a folded term stays below 128. Only the bench's complete runs can show the numeric results: the two folding rules, the configuration masking and the wrap to 16 bits. The same applies to capture at start against inputs that change later, to a word dropped when it arrives with start, and to restart in mid-run.

// File: rtl/cksum_pkg.sv
package cksum_pkg;
  typedef enum logic [1:0] {
    PH_IDLE  = 2'd0,
    PH_RUN   = 2'd1,
    PH_FINAL = 2'd2,
    PH_DONE  = 2'd3
  } phase_t;
endpackage

// File: rtl/cksum_ctrl.sv
module cksum_ctrl
  import cksum_pkg::*;
#(
  parameter int NUM_WORDS = 1024
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  input  logic valid_i,
  output logic take_o,
  output logic final_o,
  output logic done_o
);
  localparam int CNT_W = $clog2(NUM_WORDS + 1);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(NUM_WORDS - 1);
  localparam logic [CNT_W-1:0] FULL_CNT = CNT_W'(NUM_WORDS);

  phase_t           phase_q, phase_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    take_o  = (phase_q == PH_RUN) && valid_i && !start_i;
    final_o = (phase_q == PH_FINAL) && !start_i;
    phase_d = phase_q;
    cnt_d   = cnt_q;
    if (start_i) begin
      phase_d = PH_RUN;
      cnt_d   = '0;
    end else begin
      case (phase_q)
        PH_RUN: begin
          if (take_o) begin
            cnt_d = cnt_q + 1'b1;
            if (cnt_q == LAST_IDX) phase_d = PH_FINAL;
          end
        end
        PH_FINAL: phase_d = PH_DONE;
        default:  phase_d = phase_q;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
    end else begin
      phase_q <= phase_d;
      cnt_q   <= cnt_d;
    end
  end

  assign done_o = (phase_q == PH_DONE);

  assert_count_bound_R7: assert property (@(posedge clk) disable iff (rst)
    cnt_q <= FULL_CNT);

  assert_done_rise_R7: assert property (@(posedge clk) disable iff (rst)
    $rose(done_o) |-> ($past(phase_q) == PH_FINAL) && (cnt_q == FULL_CNT));

  assert_done_hold_R9: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> done_o);

  assert_no_take_after_done_R8: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !take_o);
endmodule

// File: rtl/cksum_fold.sv
module cksum_fold #(
  parameter int WORD_W = 14,
  parameter int SUM_W  = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [WORD_W-1:0] word_i,
  input  logic              protect_i,
  output logic [SUM_W-1:0]  term_o
);
  localparam int HALF_W = WORD_W / 2;

  logic [HALF_W-1:0] folded;

  for (genvar g = 0; g < HALF_W; g++) begin : g_fold
    assign folded[g] = ~(word_i[g + HALF_W] ^ word_i[g]);
  end

  assign term_o = protect_i ? SUM_W'(folded) : SUM_W'(word_i);

  assert_fold_range_R4: assert property (@(posedge clk) disable iff (rst)
    protect_i |-> term_o < SUM_W'(2 ** HALF_W));

  assert_fold_ones_R4: assert property (@(posedge clk) disable iff (rst)
    protect_i && (word_i == '1) |-> term_o == SUM_W'(2 ** HALF_W - 1));
endmodule

// File: rtl/cksum_accum.sv
module cksum_accum #(
  parameter int SUM_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             clear_i,
  input  logic             take_i,
  input  logic [SUM_W-1:0] term_i,
  input  logic             final_i,
  input  logic [SUM_W-1:0] cfg_term_i,
  output logic [SUM_W-1:0] sum_o
);
  logic [SUM_W-1:0] acc_q;

  always_ff @(posedge clk) begin
    if (rst || clear_i) acc_q <= '0;
    else if (take_i)    acc_q <= acc_q + term_i;
    else if (final_i)   acc_q <= acc_q + cfg_term_i;
  end

  assign sum_o = acc_q;

  assert_clear_zero_R2: assert property (@(posedge clk) disable iff (rst)
    clear_i |=> sum_o == '0);

  assert_idle_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !clear_i && !take_i && !final_i |=> $stable(sum_o));

  assert_excl_add_R7: assert property (@(posedge clk) disable iff (rst)
    !(take_i && final_i));
endmodule

// File: rtl/cksum_acc.sv
module cksum_acc #(
  parameter int              WORD_W    = 14,
  parameter int              SUM_W     = 16,
  parameter int              NUM_WORDS = 1024,
  parameter logic [15:0]     CFG_MASK  = 16'h001F,
  parameter logic [15:0]     OFF_BIAS  = 16'h3FE0,
  parameter logic [15:0]     ON_FLAGS  = 16'h0060
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic              valid_i,
  input  logic [WORD_W-1:0] word_i,
  input  logic [WORD_W-1:0] cfg_i,
  input  logic              protect_i,
  output logic [SUM_W-1:0]  checksum_o,
  output logic              done_o
);
  logic [WORD_W-1:0] cfg_q;
  logic              prot_q;
  logic              take, fin;
  logic [SUM_W-1:0]  word_term, cfg_term, cfg_masked;

  always_ff @(posedge clk) begin
    if (rst) begin
      cfg_q  <= '0;
      prot_q <= 1'b0;
    end else if (start_i) begin
      cfg_q  <= cfg_i;
      prot_q <= protect_i;
    end
  end

  assign cfg_masked = SUM_W'(cfg_q) & SUM_W'(CFG_MASK);
  assign cfg_term   = prot_q ? (cfg_masked | SUM_W'(ON_FLAGS))
                             : (cfg_masked + SUM_W'(OFF_BIAS));

  cksum_ctrl #(.NUM_WORDS(NUM_WORDS)) u_ctrl (
    .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
    .take_o(take), .final_o(fin), .done_o(done_o)
  );

  cksum_fold #(.WORD_W(WORD_W), .SUM_W(SUM_W)) u_fold (
    .clk(clk), .rst(rst), .word_i(word_i), .protect_i(prot_q),
    .term_o(word_term)
  );

  cksum_accum #(.SUM_W(SUM_W)) u_accum (
    .clk(clk), .rst(rst), .clear_i(start_i), .take_i(take),
    .term_i(word_term), .final_i(fin), .cfg_term_i(cfg_term),
    .sum_o(checksum_o)
  );

  assert_start_idle_R2: assert property (@(posedge clk) disable iff (rst)
    start_i |=> !done_o && checksum_o == '0);

  assert_result_hold_R9: assert property (@(posedge clk) disable iff (rst)
    done_o && !start_i |=> $stable(checksum_o));
endmodule

// File: tb/cksum_acc_tb.sv
module cksum_acc_tb;
  localparam int NW = 1024;

  typedef struct packed {
    logic [13:0] base;
    logic [13:0] step;
    logic        prot;
    logic [13:0] cfg;
    logic [3:0]  gap;
  } vec_t;

  localparam vec_t VECS [0:5] = '{
    '{14'h3FFF, 14'h0000, 1'b0, 14'h3FFF, 4'd0},
    '{14'h0000, 14'h0001, 1'b0, 14'h0005, 4'd3},
    '{14'h1234, 14'h0107, 1'b1, 14'h2A1B, 4'd0},
    '{14'h0001, 14'h0081, 1'b1, 14'h0000, 4'd5},
    '{14'h2AAA, 14'h3FFF, 1'b0, 14'h3FE0, 4'd2},
    '{14'h0F0F, 14'h0033, 1'b1, 14'h3FFF, 4'd0}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        start_i = 1'b0, valid_i = 1'b0, protect_i = 1'b0;
  logic [13:0] word_i = '0, cfg_i = '0;
  logic [15:0] checksum_o;
  logic        done_o;
  int          n_chk = 0, n_fail = 0;
  bit          finished = 1'b0;

  always #2 clk = ~clk;

  cksum_acc u_dut (
    .clk(clk), .rst(rst), .start_i(start_i), .valid_i(valid_i),
    .word_i(word_i), .cfg_i(cfg_i), .protect_i(protect_i),
    .checksum_o(checksum_o), .done_o(done_o)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] model(input logic [13:0] base, input logic [13:0] step,
                                        input logic prot, input logic [13:0] cfg);
    int unsigned s = 0;
    for (int i = 0; i < NW; i++) begin
      int unsigned w = (int'(base) + i * int'(step)) % 16384;
      int unsigned hi = w / 128, lo = w % 128;
      s += prot ? (127 - (hi ^ lo)) : w;
    end
    s += prot ? ((cfg % 32) | 32'h60) : ((cfg % 32) + 32'h3FE0);
    return s[15:0];
  endfunction

  // Starts a run, changes cfg/protect inputs after capture, feeds NW words.
  task automatic run(input logic [13:0] base, input logic [13:0] step, input logic prot,
                     input logic [13:0] cfg, input int gap, input logic word_on_start);
    start_i = 1'b1; protect_i = prot; cfg_i = cfg;
    valid_i = word_on_start; word_i = 14'h3FFF;
    @(negedge clk);
    start_i = 1'b0; valid_i = 1'b0;
    protect_i = ~prot; cfg_i = ~cfg;
    chk("R2 sum cleared by start", 32'(checksum_o), 32'h0);
    chk("R2 done cleared by start", 32'(done_o), 32'h0);
    for (int i = 0; i < NW; i++) begin
      if (gap != 0 && (i % gap) == 0) begin
        valid_i = 1'b0; word_i = 14'h1555;
        @(negedge clk);
      end
      valid_i = 1'b1;
      word_i = 14'((int'(base) + i * int'(step)) % 16384);
      @(negedge clk);
    end
    valid_i = 1'b0;
    chk("R7 done low after last word", 32'(done_o), 32'h0);
    @(negedge clk);
    chk("R7 done high one cycle later", 32'(done_o), 32'h1);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    chk("R1 reset checksum", 32'(checksum_o), 32'h0);
    chk("R1 reset done", 32'(done_o), 32'h0);
    rst = 1'b0;
    // R8: valid strobes before any start
    valid_i = 1'b1; word_i = 14'h3FFF;
    repeat (4) @(negedge clk);
    valid_i = 1'b0;
    chk("R8 no accumulation before start", 32'(checksum_o), 32'h0);
    chk("R8 done stays low before start", 32'(done_o), 32'h0);

    // Vector table, expected results from the model (R3 R4 R5 R7 R10)
    for (int v = 0; v < 6; v++) begin
      run(VECS[v].base, VECS[v].step, VECS[v].prot, VECS[v].cfg, int'(VECS[v].gap), v[0]);
      chk(VECS[v].prot ? "R4 R5 vector result" : "R3 R5 vector result",
          32'(checksum_o),
          32'(model(VECS[v].base, VECS[v].step, VECS[v].prot, VECS[v].cfg)));
    end

    // R6 blank arrays
    run(14'h3FFF, 14'h0, 1'b0, 14'h3FFF, 0, 1'b0);
    chk("R6 blank unprotected", 32'(checksum_o), 32'h3BFF);
    run(14'h3FFF, 14'h0, 1'b1, 14'h3FFF, 0, 1'b0);
    chk("R6 blank protected", 32'(checksum_o), 32'hFC7F);

    // R4 literal fold: 1024 * 0x5E + 0x60
    run(14'h0123, 14'h0, 1'b1, 14'h0000, 0, 1'b0);
    chk("R4 fold of 0x123", 32'(checksum_o), 32'h7860);

    // R5 upper configuration bits have no effect
    run(14'h0000, 14'h0, 1'b0, 14'h3FE0, 0, 1'b0);
    chk("R5 cfg upper bits masked", 32'(checksum_o), 32'h3FE0);

    // R8 / R9: strobes after done change nothing
    valid_i = 1'b1; word_i = 14'h3FFF;
    repeat (5) @(negedge clk);
    valid_i = 1'b0;
    chk("R8 sum unchanged after done", 32'(checksum_o), 32'h3FE0);
    chk("R9 done held", 32'(done_o), 32'h1);

    // R10: restart mid-run, word on start cycle dropped
    start_i = 1'b1; protect_i = 1'b0; cfg_i = 14'h0;
    @(negedge clk);
    start_i = 1'b0;
    valid_i = 1'b1; word_i = 14'h2222;
    repeat (100) @(negedge clk);
    valid_i = 1'b0;
    chk("R10 partial run not done", 32'(done_o), 32'h0);
    run(14'h0100, 14'h0003, 1'b0, 14'h0011, 0, 1'b1);
    chk("R10 restart result", 32'(checksum_o), 32'(model(14'h0100, 14'h0003, 1'b0, 14'h0011)));

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule